// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block produces the control-store address for a microprogrammed control unit. Each clock it takes the microinstruction currently being read and produces the next microaddress. That microinstruction supplies a 3-bit sequencing op, a branch target and a condition select. The block also receives a bank of condition flags and the opcode field of the instruction register. The address is held in a register and drives the control store directly. The microinstruction fields are expected to come back from the word stored at that address.

The sequencer supports the following modes:
- Stepping to the next address.
- Unconditional jumps.
- Jumps taken only when a selected flag is set.
- Dispatch on the opcode to the first word of a machine-instruction routine.
- An execute-once branch. The single word at the branch target runs. Control then returns to the word after the branch. The return point is held in a one-entry register, so no stack is needed.

A synchronous reset restarts at address zero. A stall input freezes all sequencing state.

Top module: `useq_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, `uaddr` becomes 0 and any pending execute-once return is discarded.
- R2: While `stall` is high (and `rst` low), `uaddr` and the pending-return state keep their values across the edge.
- R3: Op 0 (continue) makes the next `uaddr` equal to `uaddr`+1, wrapping from all-ones to 0.
- R4: Op 1 (jump) makes the next `uaddr` equal to `target`.
- R5: Op 2 (conditional jump) goes to `target` when `flags[cond_sel]` is 1, otherwise to `uaddr`+1.
- R6: Op 3 (dispatch) goes to `DISP_BASE + opcode * 2**SLOT_LOG2`, truncated to the address width. With the defaults this is 0x40 + 4*opcode.
- R7: Op 4 (execute-once) goes to `target` for one cycle. The following address is the branch's own address plus 1, wrapping from all-ones to 0.
- R8: In the cycle in which the execute-once target word is presented, its op, target, condition and opcode inputs have no effect on sequencing. This includes a further op 4.
- R9: Op codes 5, 6 and 7 behave as continue.
- R10: A stall during the execute-once target cycle keeps the return pending. The return is taken on the first unstalled edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Hold all sequencing state |
| op | input | 3 | Sequencing op of the current microinstruction |
| target | input | AW | Branch target field |
| cond_sel | input | SELW | Condition flag select |
| flags | input | NCOND | Condition flags |
| opcode | input | OPW | Instruction-register opcode field |
| uaddr | output | AW | Current microaddress (registered) |

## Verification
The bench focuses on the execute-once path.
- It places a jump in the target slot and checks that the jump is ignored. A design that decodes that word would wander off instead of returning.
- It issues two execute-once ops back to back. A design that re-arms on the second op would never come back.
- It stalls during the target cycle. This exposes a design that loses the pending return.
- It issues an execute-once branch from the last address. The return must wrap to 0.

The bench also checks the false leg of a conditional jump, the highest opcode dispatch, wrap-around on continue, and a reset in the middle of an execute-once sequence. A design that keeps the stale return after that reset would jump away from 1.

// File: rtl/useq_pkg.sv
package useq_pkg;
    localparam int OPW_SEQ = 3;

    localparam logic [OPW_SEQ-1:0] SEQ_NEXT  = 3'd0;
    localparam logic [OPW_SEQ-1:0] SEQ_JUMP  = 3'd1;
    localparam logic [OPW_SEQ-1:0] SEQ_CJUMP = 3'd2;
    localparam logic [OPW_SEQ-1:0] SEQ_DISP  = 3'd3;
    localparam logic [OPW_SEQ-1:0] SEQ_EXEC1 = 3'd4;
endpackage

// File: rtl/useq_cond_pick.sv
module useq_cond_pick #(
    parameter int NCOND = 8,
    parameter int SELW  = 3
) (
    input  logic [NCOND-1:0] flags,
    input  logic [SELW-1:0]  sel,
    output logic             hit
);
    localparam int SPAN = 2 ** SELW;

    logic [SPAN-1:0] padded;

    generate
        if (NCOND >= SPAN) begin : g_trunc
            assign padded = flags[SPAN-1:0];
        end else begin : g_pad
            assign padded = {{(SPAN-NCOND){1'b0}}, flags};
        end
    endgenerate

    assign hit = padded[sel];
endmodule

// File: rtl/useq_dispatch_map.sv
module useq_dispatch_map #(
    parameter int            AW        = 8,
    parameter int            OPW       = 4,
    parameter int            SLOT_LOG2 = 2,
    parameter logic [AW-1:0] DISP_BASE = 8'h40
) (
    input  logic [OPW-1:0] opcode,
    output logic [AW-1:0]  start
);
    localparam int WW = AW + OPW + SLOT_LOG2;

    logic [WW-1:0] scaled;
    logic [WW-1:0] sum;

    generate
        if (SLOT_LOG2 == 0) begin : g_unit
            assign scaled = WW'(opcode);
        end else begin : g_slot
            assign scaled = {{AW{1'b0}}, opcode, {SLOT_LOG2{1'b0}}};
        end
    endgenerate

    assign sum   = scaled + WW'(DISP_BASE);
    assign start = sum[AW-1:0];
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
    import useq_pkg::*;
#(
    parameter int            AW        = 8,
    parameter int            NCOND     = 8,
    parameter int            SELW      = 3,
    parameter int            OPW       = 4,
    parameter int            SLOT_LOG2 = 2,
    parameter logic [AW-1:0] DISP_BASE = 8'h40
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               stall,
    input  logic [OPW_SEQ-1:0] op,
    input  logic [AW-1:0]      target,
    input  logic [SELW-1:0]    cond_sel,
    input  logic [NCOND-1:0]   flags,
    input  logic [OPW-1:0]     opcode,
    output logic [AW-1:0]      uaddr
);
    typedef struct packed {
        logic [AW-1:0] addr;
        logic [AW-1:0] ret;
        logic          pend;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic [AW-1:0] incr_addr;
    logic [AW-1:0] disp_addr;
    logic          cond_hit;
    logic          pend_q;
    logic [AW-1:0] ret_q;

    useq_cond_pick #(
        .NCOND(NCOND),
        .SELW (SELW)
    ) i_cond (
        .flags(flags),
        .sel  (cond_sel),
        .hit  (cond_hit)
    );

    useq_dispatch_map #(
        .AW       (AW),
        .OPW      (OPW),
        .SLOT_LOG2(SLOT_LOG2),
        .DISP_BASE(DISP_BASE)
    ) i_disp (
        .opcode(opcode),
        .start (disp_addr)
    );

    assign incr_addr = st_q.addr + 1'b1;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d = '0;
        end else if (!stall) begin
            if (st_q.pend) begin
                // target word of an execute-once branch: return, ignore its fields
                st_d.addr = st_q.ret;
                st_d.pend = 1'b0;
            end else begin
                case (op)
                    SEQ_JUMP:  st_d.addr = target;
                    SEQ_CJUMP: st_d.addr = cond_hit ? target : incr_addr;
                    SEQ_DISP:  st_d.addr = disp_addr;
                    SEQ_EXEC1: begin
                        st_d.addr = target;
                        st_d.ret  = incr_addr;
                        st_d.pend = 1'b1;
                    end
                    default:   st_d.addr = incr_addr;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign uaddr  = st_q.addr;
    assign pend_q = st_q.pend;
    assign ret_q  = st_q.ret;
endmodule

// File: rtl/useq_sequencer_chk.sv
module useq_sequencer_chk
    import useq_pkg::*;
#(
    parameter int AW = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               stall,
    input logic [OPW_SEQ-1:0] op,
    input logic [AW-1:0]      target,
    input logic [AW-1:0]      uaddr,
    input logic               pend,
    input logic [AW-1:0]      ret
);
    // R1
    reset_zero_chk: assert property (@(posedge clk) rst |=> (uaddr == '0 && !pend));

    // R2
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        stall |=> ($stable(uaddr) && $stable(pend)));

    // R3
    cont_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!stall && !pend && op == SEQ_NEXT) |=> uaddr == AW'($past(uaddr) + 1'b1));

    // R4
    jump_tgt_chk: assert property (@(posedge clk) disable iff (rst)
        (!stall && !pend && op == SEQ_JUMP) |=> uaddr == $past(target));

    // R7
    exec_go_chk: assert property (@(posedge clk) disable iff (rst)
        (!stall && !pend && op == SEQ_EXEC1) |=> (pend && uaddr == $past(target)));

    // R8
    exec_back_chk: assert property (@(posedge clk) disable iff (rst)
        (!stall && pend) |=> (!pend && uaddr == $past(ret)));

    // R9
    spare_op_chk: assert property (@(posedge clk) disable iff (rst)
        (!stall && !pend && op > SEQ_EXEC1) |=> uaddr == AW'($past(uaddr) + 1'b1));
endmodule

bind useq_sequencer useq_sequencer_chk #(.AW(AW)) i_chk (
    .clk   (clk),
    .rst   (rst),
    .stall (stall),
    .op    (op),
    .target(target),
    .uaddr (uaddr),
    .pend  (pend_q),
    .ret   (ret_q)
);

// File: tb/test_useq_sequencer.sv
`timescale 1ns/1ps
module test_useq_sequencer;
    localparam int AW = 8;

    typedef struct {
        logic [AW-1:0] exp;
        string         req;
    } sb_item_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          stall = 1'b0;
    logic [2:0]    op = 3'd0;
    logic [AW-1:0] target = '0;
    logic [2:0]    cond_sel = '0;
    logic [7:0]    flags = '0;
    logic [3:0]    opcode = '0;
    logic [AW-1:0] uaddr;

    sb_item_t sbq[$];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    useq_sequencer i_useq_sequencer (
        .clk(clk), .rst(rst), .stall(stall), .op(op), .target(target),
        .cond_sel(cond_sel), .flags(flags), .opcode(opcode), .uaddr(uaddr)
    );

    task automatic step(input logic r, input logic s, input logic [2:0] o,
                        input logic [AW-1:0] t, input logic [2:0] cs,
                        input logic [7:0] f, input logic [3:0] opc,
                        input logic [AW-1:0] exp, input string req);
        sb_item_t it;
        @(negedge clk);
        rst = r; stall = s; op = o; target = t; cond_sel = cs; flags = f; opcode = opc;
        it.exp = exp;
        it.req = req;
        sbq.push_back(it);
    endtask

    // monitor: compare after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sbq.size() > 0) begin
                sb_item_t it;
                it = sbq.pop_front();
                checks++;
                if (uaddr !== it.exp) begin
                    fails++;
                    $display("FAIL %s: uaddr=%h expected=%h", it.req, uaddr, it.exp);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        step(1, 0, 3'd1, 8'h55, 0, 8'h00, 0, 8'h00, "R1");
        step(1, 0, 3'd0, 8'h00, 0, 8'h00, 0, 8'h00, "R1");
        // R3 continue
        step(0, 0, 3'd0, 8'h00, 0, 8'h00, 0, 8'h01, "R3");
        step(0, 0, 3'd0, 8'h00, 0, 8'h00, 0, 8'h02, "R3");
        // R4 jump
        step(0, 0, 3'd1, 8'h20, 0, 8'h00, 0, 8'h20, "R4");
        // R5 conditional taken / not taken
        step(0, 0, 3'd2, 8'h30, 3'd2, 8'b0000_0100, 0, 8'h30, "R5");
        step(0, 0, 3'd2, 8'h50, 3'd2, 8'b1111_1011, 0, 8'h31, "R5");
        // R6 dispatch
        step(0, 0, 3'd3, 8'h00, 0, 8'h00, 4'd3, 8'h4C, "R6");
        step(0, 0, 3'd3, 8'h00, 0, 8'h00, 4'd15, 8'h7C, "R6");
        // R7 execute-once, R8 target fields ignored
        step(0, 0, 3'd4, 8'h10, 0, 8'h00, 0, 8'h10, "R7");
        step(0, 0, 3'd1, 8'h99, 0, 8'h00, 0, 8'h7D, "R8");
        step(0, 0, 3'd0, 8'h00, 0, 8'h00, 0, 8'h7E, "R7");
        // R2 stall
        step(0, 1, 3'd1, 8'h05, 0, 8'h00, 0, 8'h7E, "R2");
        // R9 spare ops
        step(0, 0, 3'd5, 8'h05, 0, 8'h00, 0, 8'h7F, "R9");
        step(0, 0, 3'd7, 8'h05, 0, 8'h00, 0, 8'h80, "R9");
        // R10 stall in target cycle
        step(0, 0, 3'd4, 8'h22, 0, 8'h00, 0, 8'h22, "R7");
        step(0, 1, 3'd1, 8'h66, 0, 8'h00, 0, 8'h22, "R10");
        step(0, 0, 3'd3, 8'h00, 0, 8'h00, 4'd1, 8'h81, "R10");
        // R3 wrap
        step(0, 0, 3'd1, 8'hFE, 0, 8'h00, 0, 8'hFE, "R4");
        step(0, 0, 3'd0, 8'h00, 0, 8'h00, 0, 8'hFF, "R3");
        step(0, 0, 3'd0, 8'h00, 0, 8'h00, 0, 8'h00, "R3");
        // R7 return wrap from last address
        step(0, 0, 3'd1, 8'hFF, 0, 8'h00, 0, 8'hFF, "R4");
        step(0, 0, 3'd4, 8'h10, 0, 8'h00, 0, 8'h10, "R7");
        step(0, 0, 3'd0, 8'h00, 0, 8'h00, 0, 8'h00, "R7");
        // R8 back-to-back execute-once: second one ignored
        step(0, 0, 3'd1, 8'h60, 0, 8'h00, 0, 8'h60, "R4");
        step(0, 0, 3'd4, 8'h70, 0, 8'h00, 0, 8'h70, "R7");
        step(0, 0, 3'd4, 8'h08, 0, 8'h00, 0, 8'h61, "R8");
        step(0, 0, 3'd0, 8'h00, 0, 8'h00, 0, 8'h62, "R8");
        // R1 reset clears pending return
        step(0, 0, 3'd4, 8'h33, 0, 8'h00, 0, 8'h33, "R7");
        step(1, 0, 3'd0, 8'h00, 0, 8'h00, 0, 8'h00, "R1");
        step(0, 0, 3'd0, 8'h00, 0, 8'h00, 0, 8'h01, "R1");
        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule